// File: doc/BRIEF.md
# Minimised Four-State Moore Recogniser

This block is a Moore state machine. On every rising clock edge it takes a 2-bit symbol, and it drives a single flag that depends only on its current state. Its behaviour is fixed by a six-state transition table. In that table two pairs of states cannot be told apart from outside: one pair is the start state and its twin, and the other pair is the third state and its twin. The block merges each pair at design time. It therefore runs on a 2-bit state register with four codes and none left unused.

The full six-state behaviour is as follows. Call the states P0 to P5. The flag is high in P0, P2 and P4, and low in P1, P3 and P5. The table below gives the next state for each input symbol.

| State | 00 | 01 | 10 | 11 |
|---|---|---|---|---|
| P0 | P0 | P1 | P2 | P3 |
| P1 | P0 | P3 | P1 | P4 |
| P2 | P1 | P3 | P2 | P4 |
| P3 | P1 | P0 | P4 | P5 |
| P4 | P0 | P1 | P2 | P5 |
| P5 | P1 | P4 | P0 | P5 |

After the merge, P4 becomes HOME and P5 becomes THREE. An integrator sees only the flag sequence, and that sequence is identical for every input stream.

Top module: `fsm4_moore_top`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it rises, the machine is in HOME (the state P0 and P4 merge into) and `flag_out` is 1.
- R2: `flag_out` is 1 exactly when the state is HOME or TWO (from P0, P4, P2), and 0 in ONE or THREE (from P1, P3, P5). It is a function of the state only.
- R3: From HOME, the symbols 00, 01, 10 and 11 lead to HOME, ONE, TWO and THREE respectively.
- R4: From ONE, the symbols 00, 01, 10 and 11 lead to HOME, THREE, ONE and HOME respectively.
- R5: From TWO, the symbols 00, 01, 10 and 11 lead to ONE, THREE, TWO and HOME respectively.
- R6: From THREE, the symbols 00, 01, 10 and 11 lead to ONE, HOME, HOME and THREE respectively.
- R7: Runs that reach P4 or P5 of the six-state table give the same flags as the four-state machine. This includes the P1 to P4 step on 11, P3 to P5 on 11, and P5 to P4 on 01.
- R8: For any input stream, the sequence of `flag_out` values equals the one the six-state table produces.
- R9: The state and `flag_out` change only on a rising edge of `clk`. A change of `sym_in` between edges has no effect on `flag_out` until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to HOME |
| sym_in | input | 2 | Input symbol sampled on each rising edge |
| flag_out | output | 1 | Moore output, high in HOME and TWO |

## Verification
ONE and THREE give the same flag, and so do HOME and TWO. For that reason every directed transition check compares the flag after the step and again after a following 00 step. The 00 step sends HOME and ONE to a high flag, and TWO and THREE to a low one. A design that swapped two targets with equal flags would fail that second compare.

Walks through P4 and P5 of the six-state table catch a merge made wrongly, for example P5 folded into ONE, which would flip the flag one step later. A long random stream is compared against the six-state model to catch any remaining table error. A symbol changed in the middle of a cycle catches an output that was made Mealy by mistake, because the flag would follow the input before the edge.

// File: rtl/fsm4_pkg.sv
package fsm4_pkg;

    localparam int SYM_W = 2;
    localparam int ST_W  = 2;

    typedef enum logic [ST_W-1:0] {
        ST_HOME  = 2'b00,
        ST_ONE   = 2'b01,
        ST_TWO   = 2'b10,
        ST_THREE = 2'b11
    } st_e;

    typedef struct packed {
        st_e  state;
        logic flag;
    } fsm_regs_t;

endpackage

// File: rtl/fsm4_next.sv
module fsm4_next
    import fsm4_pkg::*;
(
    input  st_e              cur_st,
    input  logic [SYM_W-1:0] sym,
    output st_e              nxt_st
);

    // Next-state table of the merged machine.
    always_comb begin
        nxt_st = ST_HOME;
        unique case (cur_st)
            ST_HOME: begin
                unique case (sym)
                    2'b00:   nxt_st = ST_HOME;
                    2'b01:   nxt_st = ST_ONE;
                    2'b10:   nxt_st = ST_TWO;
                    default: nxt_st = ST_THREE;
                endcase
            end
            ST_ONE: begin
                unique case (sym)
                    2'b00:   nxt_st = ST_HOME;
                    2'b01:   nxt_st = ST_THREE;
                    2'b10:   nxt_st = ST_ONE;
                    default: nxt_st = ST_HOME;
                endcase
            end
            ST_TWO: begin
                unique case (sym)
                    2'b00:   nxt_st = ST_ONE;
                    2'b01:   nxt_st = ST_THREE;
                    2'b10:   nxt_st = ST_TWO;
                    default: nxt_st = ST_HOME;
                endcase
            end
            default: begin
                unique case (sym)
                    2'b00:   nxt_st = ST_ONE;
                    2'b01:   nxt_st = ST_HOME;
                    2'b10:   nxt_st = ST_HOME;
                    default: nxt_st = ST_THREE;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/fsm4_out.sv
module fsm4_out
    import fsm4_pkg::*;
(
    input  st_e  st,
    output logic flag
);

    // The flag depends on the state alone.
    always_comb begin
        unique case (st)
            ST_HOME, ST_TWO: flag = 1'b1;
            default:         flag = 1'b0;
        endcase
    end

endmodule

// File: rtl/fsm4_moore_top.sv
module fsm4_moore_top
    import fsm4_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] sym_in,
    output logic             flag_out
);

    fsm_regs_t r_d, r_q;
    st_e       nxt_st;
    logic      nxt_flag;

    fsm4_next i_next (
        .cur_st (r_q.state),
        .sym    (sym_in),
        .nxt_st (nxt_st)
    );

    fsm4_out i_out (
        .st   (nxt_st),
        .flag (nxt_flag)
    );

    // The flag is computed from the next state and registered alongside it.
    always_comb begin
        r_d       = r_q;
        r_d.state = nxt_st;
        r_d.flag  = nxt_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_HOME;
            r_q.flag  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign flag_out = r_q.flag;

    AST_FLAG_BY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        flag_out == (r_q.state == ST_HOME || r_q.state == ST_TWO)); // R2
    AST_HOME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_HOME && sym_in == 2'b00) |=> r_q.state == ST_HOME); // R3
    AST_ONE_TO_THREE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ONE && sym_in == 2'b01) |=> r_q.state == ST_THREE); // R4
    AST_TWO_TO_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_TWO && sym_in == 2'b11) |=> r_q.state == ST_HOME); // R5
    AST_THREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_THREE && sym_in == 2'b11) |=> r_q.state == ST_THREE); // R6
    AST_FLAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(r_q.state) |-> $stable(flag_out)); // R9

endmodule

// File: tb/test_fsm4_moore_top.sv
module test_fsm4_moore_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sym_in = 2'b00;
    logic       flag_out;

    int total = 0;
    int bad = 0;
    int ref_st = 0;
    bit done = 1'b0;

    fsm4_moore_top i_fsm4_moore_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_in   (sym_in),
        .flag_out (flag_out)
    );

    always #5 clk = ~clk;

    // Six-state reference model (unmerged table).
    function automatic int ref_next(input int s, input logic [1:0] x);
        case (s)
            0: ref_next = (x == 0) ? 0 : (x == 1) ? 1 : (x == 2) ? 2 : 3;
            1: ref_next = (x == 0) ? 0 : (x == 1) ? 3 : (x == 2) ? 1 : 4;
            2: ref_next = (x == 0) ? 1 : (x == 1) ? 3 : (x == 2) ? 2 : 4;
            3: ref_next = (x == 0) ? 1 : (x == 1) ? 0 : (x == 2) ? 4 : 5;
            4: ref_next = (x == 0) ? 0 : (x == 1) ? 1 : (x == 2) ? 2 : 5;
            default: ref_next = (x == 0) ? 1 : (x == 1) ? 4 : (x == 2) ? 0 : 5;
        endcase
    endfunction

    function automatic logic ref_flag(input int s);
        ref_flag = (s == 0 || s == 2 || s == 4);
    endfunction

    task automatic check(input string req, input logic exp);
        total++;
        if (flag_out !== exp) begin
            bad++;
            $display("FAIL %s: flag_out=%b expected=%b (ref state P%0d)", req, flag_out, exp, ref_st);
        end
    endtask

    // Drive a symbol at the negedge, take the edge, sample at the next negedge.
    task automatic step(input logic [1:0] x);
        sym_in = x;
        @(posedge clk);
        ref_st = ref_next(ref_st, x);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sym_in = 2'b00;
        ref_st = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Step, compare; then a 00 probe that separates states with equal flags.
    task automatic step_probe(input string req, input logic [1:0] x);
        step(x);
        check(req, ref_flag(ref_st));
        step(2'b00);
        check(req, ref_flag(ref_st));
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1", 1'b1);
        do_reset();
        check("R1", 1'b1);
        check("R2", 1'b1);
    endtask

    task automatic t_from_home();
        for (int x = 0; x < 4; x++) begin
            do_reset();
            step_probe("R3", x[1:0]);
        end
    endtask

    task automatic t_from_one();
        for (int x = 0; x < 4; x++) begin
            do_reset();
            step(2'b01);
            check("R2", 1'b0);
            step_probe("R4", x[1:0]);
        end
    endtask

    task automatic t_from_two();
        for (int x = 0; x < 4; x++) begin
            do_reset();
            step(2'b10);
            check("R2", 1'b1);
            step_probe("R5", x[1:0]);
        end
    endtask

    task automatic t_from_three();
        for (int x = 0; x < 4; x++) begin
            do_reset();
            step(2'b11);
            check("R2", 1'b0);
            step_probe("R6", x[1:0]);
        end
    endtask

    task automatic t_merged();
        // Reach P4 via P1, then try every symbol from it.
        for (int x = 0; x < 4; x++) begin
            do_reset();
            step(2'b01);
            step(2'b11);
            check("R7", ref_flag(ref_st));
            step_probe("R7", x[1:0]);
        end
        // Reach P5 via P3, then try every symbol from it.
        for (int x = 0; x < 4; x++) begin
            do_reset();
            step(2'b11);
            step(2'b11);
            check("R7", ref_flag(ref_st));
            step_probe("R7", x[1:0]);
        end
    endtask

    task automatic t_moore();
        logic held;
        do_reset();
        step(2'b10);
        held = flag_out;
        sym_in = 2'b00;
        #1;
        check("R9", held);
        sym_in = 2'b11;
        #1;
        check("R9", held);
        sym_in = 2'b01;
        #1;
        check("R9", held);
        @(posedge clk);
        ref_st = ref_next(ref_st, 2'b01);
        @(negedge clk);
        check("R9", ref_flag(ref_st));
    endtask

    task automatic t_random();
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            step(2'($urandom_range(0, 3)));
            check("R8", ref_flag(ref_st));
        end
    endtask

    initial begin
        t_reset();
        t_from_home();
        t_from_one();
        t_from_two();
        t_from_three();
        t_merged();
        t_moore();
        t_random();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule